// File: doc/BRIEF.md
# Nine-Bit Serial Port with Half-Duplex Pin Sharing

This block is an asynchronous serial transmitter and receiver behind a four-register, byte-wide bus. A character is one start bit, eight or nine data bits sent least significant bit first, and one stop bit. In nine-bit mode the extra bit does not fit the byte-wide data register. It lives in a control register bit instead, one bit for each direction. The transmit ninth bit is latched together with the byte on every data write and keeps its value between writes, so a constant mark or space bit costs no extra bus traffic. The received ninth bit is held next to the buffered byte and must be read before the data register, because that read frees the buffer for the next character.

The receiver oversamples the line sixteen times per bit. It takes each bit value from a majority vote of three samples at mid-bit and flags noise, framing, parity and overrun errors. An interrupt output combines each error flag with its own enable. A receiver-active flag tells software that a character is arriving. In single-wire mode the receiver listens to the transmit pad, and a software bit decides whether the block drives that pad. The bus is a plain register port with no back-pressure: every strobe completes in one cycle, and read data appears in the cycle after the read strobe.

Top module: `uart9_port`

## Requirements
- R1: After reset, every control bit is 0. The status register (address 1) reads 0x03, with bit0 = transmit holding register empty and bit1 = transmitter fully idle. Control register 1 (address 2) and control register 3 (address 3) read 0x00, and irq is low.
- R2: One bit time is 16 ticks, and one tick is CLK_DIV clocks. A frame is a 0 start bit, then data bits with the least significant bit first (bit 8 included when control register 1 bit2 enables nine-bit mode), then a 1 stop bit. The transmitter is enabled by control register 1 bit0.
- R3: While the transmitter has nothing to send, tx_o stays at 1.
- R4: A write to the data register (address 0) captures the byte together with the current transmit ninth bit (control register 3 bit6). That ninth bit keeps its value across later data writes.
- R5: Status bit3 (receiver active) rises when the receiver sees a start edge. It stays high for the rest of the character and clears once the line has stayed at mark for one full character time while the receiver waits for a start bit. The receiver is enabled by control register 1 bit1.
- R6: Control register 3 bit7 is read-only and returns the ninth bit of the buffered character. It reads 0 for eight-bit characters. Bit4 always reads 0.
- R7: A read of the data register returns the buffered byte. In the same cycle it clears status bit2 (buffer full) and the error flags in status bits 4 to 7.
- R8: A character that completes while the buffer is full is discarded. The buffer keeps its byte, and status bit4 (overrun) is set.
- R9: Control register 1 bit5 enables loop mode and bit6 selects the receiver source. With loop set and the source bit clear, the receiver hears the transmit line internally. With both set (single-wire mode), the receiver hears the tx_i pad, and tx_oe equals control register 3 bit5. In every other mode tx_oe is 1.
- R10: irq is the OR of overrun with the control register 3 bit3 enable, noise with the bit2 enable, framing error with the bit1 enable, and parity error with the bit0 enable.
- R11: The receiver takes each bit from a majority of samples 7, 8 and 9 of the 16. If the three samples disagree in any bit of a character, status bit5 (noise) is set for that character.
- R12: A stop bit sampled as 0 sets status bit6 (framing error). The byte is still buffered.
- R13: Control register 1 bit3 enables parity, and bit4 selects odd parity (even when clear). The parity bit takes the last data position: bit 7 in eight-bit mode, bit 8 in nine-bit mode. The transmitter inserts it, and a mismatch on receive sets status bit7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select: 0 data, 1 status, 2 control 1, 3 control 3 |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| rx_i | input | 1 | Receive pin |
| tx_i | input | 1 | Level seen on the transmit pad |
| tx_o | output | 1 | Transmit pin drive value |
| tx_oe | output | 1 | Transmit pin output enable |
| irq | output | 1 | Error interrupt request |

## Verification
Most corrupted internal state reaches the ports within a single character. A sampling point off by one tick turns the injected mid-bit glitch into either no noise flag or a wrong byte. A miscounted bit index shifts every swept byte, and a lost ninth bit shows in control register 3 bit7 on the next read. A buffer that takes a character while full changes the data register read right after the second frame. A receiver-active flag that clears too early or too late is caught by status reads taken mid-frame and one character time after the frame. Pin-direction or idle-line faults are visible on tx_oe and tx_o in the very cycle after the control write.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  localparam int OVS       = 16;
  localparam int SUBW      = $clog2(OVS);
  localparam int FRAME_MAX = 11;
  localparam int BCNTW     = 4;
  localparam int IDLE_W    = $clog2(FRAME_MAX * OVS + 1);
  localparam int SMP_MID   = OVS / 2;

  typedef enum logic [1:0] {
    A_DATA = 2'd0,
    A_STAT = 2'd1,
    A_CTL1 = 2'd2,
    A_CTL3 = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic rx_src;
    logic loop;
    logic par_odd;
    logic par_en;
    logic nine;
    logic rx_en;
    logic tx_en;
  } ctl1_t;

  typedef struct packed {
    logic pf;
    logic fe;
    logic nf;
  } rx_err_t;

  function automatic logic par_bit(input logic [8:0] d, input logic nine, input logic odd);
    logic x;
    x = nine ? ^d[7:0] : ^d[6:0];
    return x ^ odd;
  endfunction
endpackage

// File: rtl/uart9_tick.sv
module uart9_tick #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx
  import uart9_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       nine,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       wr,
  input  logic [8:0] wdata9,
  output logic       line,
  output logic       busy,
  output logic       hold_empty
);
  logic [8:0]           hold_q;
  logic                 full_q;
  logic [FRAME_MAX-1:0] sh_q;
  logic [BCNTW-1:0]     left_q;
  logic [SUBW-1:0]      sub_q;
  logic                 busy_q;
  logic                 start;
  logic [8:0]           d9;
  logic [FRAME_MAX-1:0] frame;

  assign start = en && full_q && !busy_q;

  always_comb begin
    d9 = hold_q;
    if (par_en) begin
      if (nine) d9[8] = par_bit(hold_q, nine, par_odd);
      else      d9[7] = par_bit(hold_q, nine, par_odd);
    end
    frame = nine ? {1'b1, d9, 1'b0} : {2'b11, d9[7:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      sub_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (wr) begin
        hold_q <= wdata9;
        full_q <= 1'b1;
      end else if (start) begin
        full_q <= 1'b0;
      end
      if (start) begin
        sh_q   <= frame;
        left_q <= nine ? BCNTW'(FRAME_MAX) : BCNTW'(FRAME_MAX - 1);
        sub_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q && tick) begin
        if (sub_q == SUBW'(OVS - 1)) begin
          sub_q  <= '0;
          sh_q   <= {1'b1, sh_q[FRAME_MAX-1:1]};
          left_q <= left_q - 1'b1;
          if (left_q == BCNTW'(1)) busy_q <= 1'b0;
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end
    end
  end

  assign line       = busy_q ? sh_q[0] : 1'b1;
  assign busy       = busy_q;
  assign hold_empty = !full_q;
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
  import uart9_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       nine,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rxd,
  output logic       done,
  output logic [8:0] data,
  output rx_err_t    err,
  output logic       active
);
  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_st_e;

  localparam logic [SUBW-1:0] SA   = SUBW'(SMP_MID - 1);
  localparam logic [SUBW-1:0] SB   = SUBW'(SMP_MID);
  localparam logic [SUBW-1:0] SC   = SUBW'(SMP_MID + 1);
  localparam logic [SUBW-1:0] SEND = SUBW'(OVS - 1);

  rx_st_e            st_q;
  logic [SUBW-1:0]   sub_q;
  logic [BCNTW-1:0]  idx_q;
  logic [8:0]        sh_q;
  logic [1:0]        smp_q;
  logic              noisy_q;
  logic [IDLE_W-1:0] idle_q;
  logic              act_q;
  logic              done_q;
  logic [8:0]        data_q;
  rx_err_t           err_q;

  logic              maj, dis;
  logic [BCNTW-1:0]  last_idx;
  logic [IDLE_W-1:0] idle_len;
  logic [8:0]        rcv;
  logic              par_rx;

  assign maj      = (smp_q[0] & smp_q[1]) | (smp_q[0] & rxd) | (smp_q[1] & rxd);
  assign dis      = !((smp_q[0] == smp_q[1]) && (smp_q[1] == rxd));
  assign last_idx = nine ? BCNTW'(8) : BCNTW'(7);
  assign idle_len = nine ? IDLE_W'(FRAME_MAX * OVS) : IDLE_W'((FRAME_MAX - 1) * OVS);
  assign rcv      = nine ? sh_q : {1'b0, sh_q[8:1]};
  assign par_rx   = nine ? rcv[8] : rcv[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      sub_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      smp_q   <= '0;
      noisy_q <= 1'b0;
      idle_q  <= '0;
      act_q   <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
      err_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!en) begin
        st_q   <= S_IDLE;
        act_q  <= 1'b0;
        idle_q <= '0;
      end else if (tick) begin
        if (st_q == S_IDLE) begin
          if (!rxd) begin
            st_q    <= S_START;
            sub_q   <= '0;
            noisy_q <= 1'b0;
            act_q   <= 1'b1;
            idle_q  <= '0;
          end else begin
            if (idle_q != '1) idle_q <= idle_q + 1'b1;
            if (idle_q + 1'b1 >= idle_len) act_q <= 1'b0;
          end
        end else begin
          sub_q <= sub_q + 1'b1;
          if (sub_q == SA) smp_q[0] <= rxd;
          if (sub_q == SB) smp_q[1] <= rxd;
          case (st_q)
            S_START: begin
              if (sub_q == SC) begin
                noisy_q <= dis;
                if (maj) begin
                  st_q   <= S_IDLE;
                  idle_q <= '0;
                end
              end
              if (sub_q == SEND) begin
                st_q  <= S_DATA;
                idx_q <= '0;
              end
            end
            S_DATA: begin
              if (sub_q == SC) begin
                sh_q    <= {maj, sh_q[8:1]};
                noisy_q <= noisy_q | dis;
              end
              if (sub_q == SEND) begin
                if (idx_q == last_idx) st_q <= S_STOP;
                else                   idx_q <= idx_q + 1'b1;
              end
            end
            default: begin
              if (sub_q == SC) begin
                done_q   <= 1'b1;
                data_q   <= rcv;
                err_q.fe <= !maj;
                err_q.nf <= noisy_q | dis;
                err_q.pf <= par_en && (par_bit(rcv, nine, par_odd) != par_rx);
                st_q     <= S_IDLE;
                idle_q   <= '0;
              end
            end
          endcase
        end
      end
    end
  end

  assign done   = done_q;
  assign data   = data_q;
  assign err    = err_q;
  assign active = act_q;
endmodule

// File: rtl/uart9_port.sv
module uart9_port
  import uart9_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rx_i,
  input  logic       tx_i,
  output logic       tx_o,
  output logic       tx_oe,
  output logic       irq
);
  reg_addr_e  a;
  ctl1_t      ctl1_q;
  logic       t9_q, txdir_q;
  logic [3:0] ie_q;
  logic [8:0] rx_buf_q;
  logic       rx_full_q, ov_q;
  rx_err_t    err_q;
  logic [7:0] rdata_q;
  logic       rx_s1, rx_s2;

  logic       tick, tx_line, tx_busy, tx_hempty;
  logic       rx_done, rx_active, rx_raw;
  logic [8:0] rx_data;
  rx_err_t    rx_err;
  logic       single_wire, rd_clr, tx_wr;
  logic [7:0] stat, ctl3_rd;

  assign a           = reg_addr_e'(addr);
  assign rd_clr      = rd_en && (a == A_DATA);
  assign tx_wr       = wr_en && (a == A_DATA);
  assign single_wire = ctl1_q.loop && ctl1_q.rx_src;
  assign rx_raw      = !ctl1_q.loop ? rx_i : (ctl1_q.rx_src ? tx_i : tx_line);

  uart9_tick #(.CLK_DIV(CLK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  uart9_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(ctl1_q.tx_en), .nine(ctl1_q.nine),
    .par_en(ctl1_q.par_en), .par_odd(ctl1_q.par_odd), .wr(tx_wr),
    .wdata9({t9_q, wdata}), .line(tx_line), .busy(tx_busy), .hold_empty(tx_hempty)
  );

  uart9_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(ctl1_q.rx_en), .nine(ctl1_q.nine),
    .par_en(ctl1_q.par_en), .par_odd(ctl1_q.par_odd), .rxd(rx_s2),
    .done(rx_done), .data(rx_data), .err(rx_err), .active(rx_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
    end else begin
      rx_s1 <= rx_raw;
      rx_s2 <= rx_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl1_q  <= '0;
      t9_q    <= 1'b0;
      txdir_q <= 1'b0;
      ie_q    <= '0;
    end else if (wr_en) begin
      if (a == A_CTL1) ctl1_q <= ctl1_t'(wdata[6:0]);
      if (a == A_CTL3) begin
        t9_q    <= wdata[6];
        txdir_q <= wdata[5];
        ie_q    <= wdata[3:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf_q  <= '0;
      rx_full_q <= 1'b0;
      ov_q      <= 1'b0;
      err_q     <= '0;
    end else begin
      if (rd_clr) begin
        rx_full_q <= 1'b0;
        ov_q      <= 1'b0;
        err_q     <= '0;
      end
      if (rx_done) begin
        if (rx_full_q && !rd_clr) begin
          ov_q <= 1'b1;
        end else begin
          rx_buf_q  <= rx_data;
          rx_full_q <= 1'b1;
          err_q     <= rx_err;
        end
      end
    end
  end

  assign stat    = {err_q.pf, err_q.fe, err_q.nf, ov_q, rx_active, rx_full_q,
                    (tx_hempty && !tx_busy), tx_hempty};
  assign ctl3_rd = {rx_buf_q[8], t9_q, txdir_q, 1'b0, ie_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd_en) begin
      case (a)
        A_DATA:  rdata_q <= rx_buf_q[7:0];
        A_STAT:  rdata_q <= stat;
        A_CTL1:  rdata_q <= {1'b0, ctl1_q};
        default: rdata_q <= ctl3_rd;
      endcase
    end
  end

  assign rdata = rdata_q;
  assign tx_o  = tx_line;
  assign tx_oe = single_wire ? txdir_q : 1'b1;
  assign irq   = (ov_q & ie_q[3]) | (err_q.nf & ie_q[2]) | (err_q.fe & ie_q[1]) | (err_q.pf & ie_q[0]);
endmodule

// File: rtl/uart9_port_chk.sv
module uart9_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic [3:0] ie,
  input logic       rx_done,
  input logic       rx_full,
  input logic [8:0] rx_buf,
  input logic       ov,
  input logic       rx_active,
  input logic       tx_o,
  input logic       tx_oe,
  input logic       tx_busy,
  input logic       single,
  input logic       rd_clr
);
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ie == 4'b0000) |-> !irq);

  p_keep_buf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && rx_done && !rd_clr) |=> ($stable(rx_buf) && ov));

  p_active_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> rx_active);

  p_line_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_o);

  p_oe_normal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !single |-> tx_oe);

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !rx_done) |=> !rx_full);
endmodule

bind uart9_port uart9_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .ie(ie_q), .rx_done(rx_done),
  .rx_full(rx_full_q), .rx_buf(rx_buf_q), .ov(ov_q), .rx_active(rx_active),
  .tx_o(tx_o), .tx_oe(tx_oe), .tx_busy(tx_busy), .single(single_wire), .rd_clr(rd_clr)
);

// File: tb/uart9_port_test.sv
`timescale 1ns/1ps
module uart9_port_test;
  localparam int DIV    = 1;
  localparam int BITCLK = 16 * DIV;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       ext_rx = 1'b1, ext_pad = 1'b1;
  logic       tx_o, tx_oe, irq, tx_pad;
  int         nchk = 0, nfail = 0;

  assign tx_pad = tx_oe ? tx_o : ext_pad;

  uart9_port #(.CLK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rx_i(ext_rx), .tx_i(tx_pad),
    .tx_o(tx_o), .tx_oe(tx_oe), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wait_rx(input string tag);
    logic [7:0] s;
    bit got = 0;
    for (int n = 0; n < 4000 && !got; n++) begin
      rd_reg(2'd1, s);
      got = s[2];
    end
    check(tag, {31'd0, got}, 32'd1);
  endtask

  task automatic send_ext(input logic [8:0] d, input int nb, input logic stopv,
                          input int glitch, input bit on_pad);
    for (int k = 0; k < nb + 2; k++) begin
      logic b;
      b = (k == 0) ? 1'b0 : ((k == nb + 1) ? stopv : d[k-1]);
      for (int c = 0; c < BITCLK; c++) begin
        logic v;
        @(negedge clk);
        v = (k == glitch && c == 8 * DIV) ? ~b : b;
        if (on_pad) ext_pad = v; else ext_rx = v;
      end
    end
    @(negedge clk);
    ext_rx = 1'b1; ext_pad = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [10:0] fr;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R3 idle line, R9 default output enable
    rd_reg(2'd1, r); check("R1 status", r, 8'h03);
    rd_reg(2'd2, r); check("R1 ctl1", r, 8'h00);
    rd_reg(2'd3, r); check("R1 ctl3", r, 8'h00);
    check("R1 irq", irq, 0);
    check("R3 idle tx", tx_o, 1);
    check("R9 oe normal", tx_oe, 1);

    // R2 sweep all bytes through internal loop, 8-bit; R6 ninth reads 0
    wr_reg(2'd2, 8'h23);
    for (int v = 0; v < 256; v++) begin
      wr_reg(2'd0, v[7:0]);
      wait_rx("R2 loop8 arrival");
      rd_reg(2'd3, r); check("R6 r9 zero in 8-bit", r[7], 0);
      rd_reg(2'd0, r); check("R2 loop8 data", r, v[7:0]);
    end

    // R4 ninth bit latched and retained; R6 returned in ctl3 bit7
    wr_reg(2'd2, 8'h27);
    for (int t = 0; t < 2; t++) begin
      wr_reg(2'd3, t[0] ? 8'h40 : 8'h00);
      for (int i = 0; i < 64; i++) begin
        logic [7:0] v;
        v = 8'((i * 37 + t * 11) & 255);
        wr_reg(2'd0, v);
        wait_rx("R4 loop9 arrival");
        rd_reg(2'd3, r); check("R4 R6 ninth bit", r[7], t[0]);
        rd_reg(2'd0, r); check("R2 loop9 data", r, v);
      end
    end

    // R13 odd parity in 9-bit mode: 0x0F has even ones -> parity 1
    wr_reg(2'd2, 8'h3F);
    wr_reg(2'd3, 8'h00);
    wr_reg(2'd0, 8'h0F);
    wait_rx("R13 parity arrival");
    rd_reg(2'd1, r); check("R13 no parity error", r[7], 0);
    rd_reg(2'd3, r); check("R13 tx parity bit", r[7], 1);
    rd_reg(2'd0, r); check("R13 data", r, 8'h0F);

    // R2 pin-level frame, 9-bit, ninth=1, byte 0xA5
    wr_reg(2'd2, 8'h07);
    wr_reg(2'd3, 8'h40);
    wr_reg(2'd0, 8'hA5);
    fr = {1'b1, 1'b1, 8'hA5, 1'b0};
    for (int n = 0; n < 200 && tx_o; n++) @(negedge clk);
    for (int k = 0; k < 11; k++) begin
      if (k == 0) repeat (8 * DIV) @(negedge clk);
      else repeat (BITCLK) @(negedge clk);
      check("R2 frame bit", tx_o, fr[k]);
    end
    repeat (20) @(negedge clk);
    check("R3 line high after frame", tx_o, 1);
    rd_reg(2'd1, r); check("R3 tx idle", r[1:0], 2'b11);

    // R5 receiver active, external line, 8-bit
    wr_reg(2'd3, 8'h00);
    wr_reg(2'd2, 8'h02);
    fork
      send_ext(9'h096, 8, 1'b1, -1, 0);
      begin
        logic [7:0] s;
        repeat (3 * BITCLK) @(negedge clk);
        rd_reg(2'd1, s); check("R5 active mid frame", s[3], 1);
      end
    join
    wait_rx("R5 arrival");
    rd_reg(2'd1, r); check("R5 active after stop", r[3], 1);
    repeat (12 * BITCLK) @(negedge clk);
    rd_reg(2'd1, r); check("R5 idle clears active", r[3:2], 2'b01);
    // R7 read clears
    rd_reg(2'd0, r); check("R7 data", r, 8'h96);
    rd_reg(2'd1, r); check("R7 flags cleared", r & 8'hF4, 8'h00);

    // R8 overrun and R10 enable gating
    send_ext(9'h011, 8, 1'b1, -1, 0);
    send_ext(9'h022, 8, 1'b1, -1, 0);
    repeat (4) @(negedge clk);
    rd_reg(2'd1, r); check("R8 overrun flag", r[4], 1);
    wr_reg(2'd3, 8'h07); check("R10 irq masked", irq, 0);
    wr_reg(2'd3, 8'h08); check("R10 irq overrun", irq, 1);
    rd_reg(2'd0, r); check("R8 kept first", r, 8'h11);
    rd_reg(2'd1, r); check("R8 overrun cleared", r[4], 0);
    check("R10 irq drops", irq, 0);
    wr_reg(2'd3, 8'h00);

    // R11 noise: glitch sample 8 of data bit3
    send_ext(9'h03C, 8, 1'b1, 4, 0);
    repeat (4) @(negedge clk);
    rd_reg(2'd1, r); check("R11 noise flag", r[7:5], 3'b001);
    rd_reg(2'd0, r); check("R11 majority data", r, 8'h3C);

    // R12 framing error
    send_ext(9'h055, 8, 1'b0, -1, 0);
    repeat (32) @(negedge clk);
    rd_reg(2'd1, r); check("R12 framing flag", r[6], 1);
    wr_reg(2'd3, 8'h02); check("R10 irq framing", irq, 1);
    rd_reg(2'd0, r); check("R12 data kept", r, 8'h55);
    check("R10 irq after read", irq, 0);
    wr_reg(2'd3, 8'h00);

    // R13 even parity in 8-bit mode
    wr_reg(2'd2, 8'h0A);
    send_ext(9'h035, 8, 1'b1, -1, 0);
    repeat (4) @(negedge clk);
    rd_reg(2'd1, r); check("R13 good parity", r[7], 0);
    rd_reg(2'd0, r); check("R13 data good", r, 8'h35);
    send_ext(9'h0B5, 8, 1'b1, -1, 0);
    repeat (4) @(negedge clk);
    rd_reg(2'd1, r); check("R13 bad parity", r[7], 1);
    rd_reg(2'd0, r); check("R13 data bad", r, 8'hB5);

    // R9 single-wire: receive from pad, then transmit onto pad
    wr_reg(2'd2, 8'h63);
    check("R9 oe off", tx_oe, 0);
    send_ext(9'h05A, 8, 1'b1, -1, 1);
    wait_rx("R9 pad arrival");
    rd_reg(2'd0, r); check("R9 pad data", r, 8'h5A);
    wr_reg(2'd3, 8'h20);
    check("R9 oe on", tx_oe, 1);
    wr_reg(2'd0, 8'h81);
    wait_rx("R9 self arrival");
    rd_reg(2'd0, r); check("R9 self data", r, 8'h81);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule